// File: doc/BRIEF.md
# Frame-Timed Register Write Sequencer

This block runs short programs against a frame timer that never stops. The timer counts quarter-bit periods and returns to zero once per frame. A program sits in a local instruction memory and holds two kinds of instruction. The first stalls until the timer reaches an absolute count. The second writes a byte into one control register of a small synchronous serial output port. A write of the transmit code to the port's command register starts shifting out the loaded pattern. Because the waits name absolute counts, one program can schedule several serial transfers at fixed slots of a frame, and it can run across the point where the timer wraps from its last count back to zero.

Software loads programs through a plain write port into the instruction memory. It then gives a one-cycle start pulse with a start address. The sequencer carries out one instruction per quarter-bit clock. When it reads an all-zero word it stops and raises a done flag. The port sends the programmed number of bits, most significant first, on an enable, data and clock triple, and the clock's idle polarity is configurable.

Top module: `frame_seq_top`

## Requirements
- R1: `frame_cnt` is 0 after reset. It advances by one on each clock and goes from FRAME_LEN-1 (default 4999) back to 0.
- R2: Instruction encoding: bit 15 set means a wait whose target is bits 14:0. Bit 15 clear means a move with register address in bits 12:8 and data in bits 7:0, and the move writes only when bits 14:13 are zero. The all-zero word ends the program: in the next cycle `busy` is 0 and `done` is 1, and both stay that way until a new start.
- R3: A `start` pulse while idle begins execution at `start_addr` in the next cycle and clears `done`. A `start` pulse while busy is ignored.
- R4: The sequencer executes one instruction per clock. A wait holds until `frame_cnt` equals its target, and the next instruction executes in the following slot. This also holds when a program crosses the wrap to 0.
- R5: A wait whose target is 0 or is at least FRAME_LEN completes in one slot without stalling.
- R6: Port registers are: address 0x01 config (bit 0 = clock polarity), 0x02 bit count, 0x03 transmit data, 0x04 command. Writing 0x01 to the command register starts a transfer, and `ser_en` rises in the slot after that write. After a wait for T, a program that writes config, count, data and command sees `ser_en` rise at T+5. A program that writes only data and command sees it rise at T+3 (modulo FRAME_LEN).
- R7: A transfer of N bits sends bits N-1..0 of the transmit data, most significant first. Each bit is held for two clocks, and `ser_en` is high for exactly 2N clocks.
- R8: `ser_clk` rests at the polarity bit whenever `ser_en` is low. Within each bit it equals the polarity in the first clock and its inverse in the second.
- R9: When the bit count is 0, a command is ignored. A count above SER_W (default 8) is treated as SER_W.
- R10: A command written while a transfer is running is ignored. So is a command value other than 0x01. A transmit-data write during a transfer does not change the bits being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_we | input | 1 | Instruction memory write strobe |
| imem_waddr | input | AW | Instruction memory write address |
| imem_wdata | input | 16 | Instruction word to store |
| start | input | 1 | One-cycle program start pulse |
| start_addr | input | AW | First instruction address of the program |
| frame_cnt | output | CNT_W | Current frame timer count |
| busy | output | 1 | Program executing |
| done | output | 1 | Last program reached its end word |
| ser_en | output | 1 | Serial enable, high while bits are shifted |
| ser_dat | output | 1 | Serial data, MSB first |
| ser_clk | output | 1 | Serial clock with configurable polarity |

## Verification
The hardest case to produce from the ports is a program whose setup writes fall on both sides of the frame wrap. Here the wait completes at 4996, the four writes land on 4997, 4998, 4999 and 0, and the shift must begin at slot 1. The stimulus loads that program shortly after reset and lets the free-running timer carry it through the wrap. A second program then stacks a command on a transfer that is still running, sends a zero count, sends an unknown command code and sends an oversized count. A start pulse issued mid-program checks that it leaves the schedule untouched. Every transfer's first slot, bit pattern, length and clock phase are compared with values worked out from the written schedule.

// File: rtl/fs_pkg.sv
// Shared constants and types of the frame-timed sequencer.
// Assumes 16-bit instruction words and byte-wide port registers.
package fs_pkg;
    localparam int INSTR_W  = 16;
    localparam int RADDR_W  = 5;
    localparam int RDATA_W  = 8;
    localparam int TGT_W    = 15;

    localparam logic [RADDR_W-1:0] REG_CONFIG = 5'h01;
    localparam logic [RADDR_W-1:0] REG_COUNT  = 5'h02;
    localparam logic [RADDR_W-1:0] REG_TXDATA = 5'h03;
    localparam logic [RADDR_W-1:0] REG_CMD    = 5'h04;

    localparam logic [RDATA_W-1:0] CMD_SEND   = 8'h01;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/fs_frame_counter.sv
// Free-running frame timer: counts quarter-bit clocks from 0 to
// FRAME_LEN-1 and wraps. Assumes one clock per quarter bit.
module fs_frame_counter #(
    parameter int FRAME_LEN = 5000,
    localparam int CNT_W = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    // advance and wrap the frame count
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/fs_sequencer.sv
// Instruction memory, fetch and decode. Executes one word per clock.
// Waits stall until the frame count equals the target. Moves are emitted
// as a one-cycle register write strobe. The zero word stops the program.
// Assumes the memory is loaded before a start pulse is given.
module fs_sequencer
    import fs_pkg::*;
#(
    parameter int AW        = 6,
    parameter int FRAME_LEN = 5000,
    localparam int CNT_W = $clog2(FRAME_LEN),
    localparam int DEPTH = 1 << AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               imem_we,
    input  logic [AW-1:0]      imem_waddr,
    input  logic [INSTR_W-1:0] imem_wdata,
    input  logic               start,
    input  logic [AW-1:0]      start_addr,
    input  logic [CNT_W-1:0]   frame_cnt,
    output logic               reg_we,
    output logic [RADDR_W-1:0] reg_addr,
    output logic [RDATA_W-1:0] reg_wdata,
    output logic               busy,
    output logic               done
);
    localparam logic [TGT_W-1:0] FRAME_LEN_T = TGT_W'(FRAME_LEN);

    logic [INSTR_W-1:0] mem [DEPTH];
    seq_state_t         state;
    logic [AW-1:0]      pc;
    logic [INSTR_W-1:0] instr;
    logic               is_end, is_wait, wait_go, advance;
    logic [TGT_W-1:0]   tgt, cnt_ext;

    // store words from the load port
    always_ff @(posedge clk) begin
        if (imem_we)
            mem[imem_waddr] <= imem_wdata;
    end

    // decode the current word
    always_comb begin
        instr   = mem[pc];
        is_end  = (instr == '0);
        is_wait = instr[INSTR_W-1];
        tgt     = instr[TGT_W-1:0];
        cnt_ext = TGT_W'(frame_cnt);
        wait_go = (tgt == '0) || (tgt >= FRAME_LEN_T) || (tgt == cnt_ext);
        advance = (state == SEQ_RUN) && !is_end && (!is_wait || wait_go);
    end

    // register write strobe for a valid move
    always_comb begin
        reg_we    = (state == SEQ_RUN) && !is_wait && !is_end
                    && (instr[14:13] == 2'b00);
        reg_addr  = instr[12:8];
        reg_wdata = instr[7:0];
    end

    // program counter, run state and completion flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            pc    <= '0;
            done  <= 1'b0;
        end else if (state == SEQ_IDLE) begin
            if (start) begin
                state <= SEQ_RUN;
                pc    <= start_addr;
                done  <= 1'b0;
            end
        end else if (is_end) begin
            state <= SEQ_IDLE;
            done  <= 1'b1;
        end else if (advance) begin
            pc <= pc + AW'(1);
        end
    end

    assign busy = (state == SEQ_RUN);
endmodule

// File: rtl/fs_serial_port.sv
// Control registers and serial shifter. A command write of the send code
// loads the low N data bits, MSB aligned, and shifts them out two clocks
// per bit. Assumes SER_W does not exceed the register data width.
module fs_serial_port
    import fs_pkg::*;
#(
    parameter int SER_W = 8,
    localparam int CW = $clog2(SER_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [RDATA_W-1:0] reg_wdata,
    output logic               ser_en,
    output logic               ser_dat,
    output logic               ser_clk,
    output logic               pol_o,
    output logic               count_nz_o
);
    localparam logic [RDATA_W-1:0] SER_W_B = RDATA_W'(SER_W);

    logic              pol_q;
    logic [RDATA_W-1:0] count_q;
    logic [SER_W-1:0]  tx_q;
    logic              active, phase;
    logic [CW-1:0]     left;
    logic [SER_W-1:0]  sh;
    logic [CW-1:0]     n_eff;
    logic              go;

    // clamp the bit count and qualify a send command
    always_comb begin
        n_eff = (count_q > SER_W_B) ? CW'(SER_W) : count_q[CW-1:0];
        go    = reg_we && (reg_addr == REG_CMD) && (reg_wdata == CMD_SEND)
                && !active && (count_q != '0);
    end

    // configuration, count and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q   <= 1'b0;
            count_q <= '0;
            tx_q    <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                REG_CONFIG: pol_q   <= reg_wdata[0];
                REG_COUNT:  count_q <= reg_wdata;
                REG_TXDATA: tx_q    <= reg_wdata[SER_W-1:0];
                default:    ;
            endcase
        end
    end

    // shift engine: two clocks per bit, MSB first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            phase  <= 1'b0;
            left   <= '0;
            sh     <= '0;
        end else if (go) begin
            active <= 1'b1;
            phase  <= 1'b0;
            left   <= n_eff;
            sh     <= tx_q << (SER_W - int'(n_eff));
        end else if (active) begin
            if (phase) begin
                phase <= 1'b0;
                sh    <= sh << 1;
                left  <= left - CW'(1);
                if (left == CW'(1))
                    active <= 1'b0;
            end else begin
                phase <= 1'b1;
            end
        end
    end

    assign ser_en     = active;
    assign ser_dat    = active & sh[SER_W-1];
    assign ser_clk    = pol_q ^ (active & phase);
    assign pol_o      = pol_q;
    assign count_nz_o = (count_q != '0);
endmodule

// File: rtl/frame_seq_top.sv
// Top of the frame-timed register write sequencer: frame timer,
// program sequencer and serial output port. Assumes clk is the
// quarter-bit clock.
module frame_seq_top
    import fs_pkg::*;
#(
    parameter int FRAME_LEN = 5000,
    parameter int AW        = 6,
    parameter int SER_W     = 8,
    localparam int CNT_W = $clog2(FRAME_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               imem_we,
    input  logic [AW-1:0]      imem_waddr,
    input  logic [INSTR_W-1:0] imem_wdata,
    input  logic               start,
    input  logic [AW-1:0]      start_addr,
    output logic [CNT_W-1:0]   frame_cnt,
    output logic               busy,
    output logic               done,
    output logic               ser_en,
    output logic               ser_dat,
    output logic               ser_clk
);
    logic               reg_we;
    logic [RADDR_W-1:0] reg_addr;
    logic [RDATA_W-1:0] reg_wdata;
    logic               pol;
    logic               count_nz;

    fs_frame_counter #(.FRAME_LEN(FRAME_LEN)) cnt_i (
        .clk (clk),
        .rst_n (rst_n),
        .cnt (frame_cnt)
    );

    fs_sequencer #(.AW(AW), .FRAME_LEN(FRAME_LEN)) seq_i (
        .clk (clk),
        .rst_n (rst_n),
        .imem_we (imem_we),
        .imem_waddr (imem_waddr),
        .imem_wdata (imem_wdata),
        .start (start),
        .start_addr (start_addr),
        .frame_cnt (frame_cnt),
        .reg_we (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata (reg_wdata),
        .busy (busy),
        .done (done)
    );

    fs_serial_port #(.SER_W(SER_W)) port_i (
        .clk (clk),
        .rst_n (rst_n),
        .reg_we (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata (reg_wdata),
        .ser_en (ser_en),
        .ser_dat (ser_dat),
        .ser_clk (ser_clk),
        .pol_o (pol),
        .count_nz_o (count_nz)
    );
endmodule

// File: rtl/fs_checks.sv
// Temporal checks on the sequencer, bound to the top module.
module fs_checks
    import fs_pkg::*;
#(
    parameter int FRAME_LEN = 5000,
    parameter int SER_W     = 8,
    localparam int CNT_W = $clog2(FRAME_LEN)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CNT_W-1:0]   frame_cnt,
    input logic               busy,
    input logic               done,
    input logic               ser_en,
    input logic               ser_clk,
    input logic               pol,
    input logic               count_nz,
    input logic               reg_we,
    input logic [RADDR_W-1:0] reg_addr,
    input logic [RDATA_W-1:0] reg_wdata
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);
    localparam int RW = $clog2(2 * SER_W + 2);

    // R1
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_cnt == LAST) |=> (frame_cnt == '0));

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_cnt != LAST) |=> (frame_cnt == $past(frame_cnt) + CNT_W'(1)));

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6
    cmd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == REG_CMD && reg_wdata == CMD_SEND
         && !ser_en && count_nz) |=> ser_en);

    // R8
    idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |-> (ser_clk == pol));

    // R8
    clk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en && $past(ser_en)) |-> (ser_clk != $past(ser_clk)));

    logic [RW-1:0] run_len;

    // count enable-high clocks of each transfer
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_len <= '0;
        else if (ser_en)
            run_len <= run_len + RW'(1);
        else
            run_len <= '0;
    end

    // R7
    always_ff @(posedge clk) begin
        if (rst_n && !ser_en && run_len != '0)
            en_len_chk: assert (!run_len[0] && run_len <= RW'(2 * SER_W));
    end
endmodule

bind frame_seq_top fs_checks #(.FRAME_LEN(FRAME_LEN), .SER_W(SER_W)) chk_i (
    .clk (clk),
    .rst_n (rst_n),
    .frame_cnt (frame_cnt),
    .busy (busy),
    .done (done),
    .ser_en (ser_en),
    .ser_clk (ser_clk),
    .pol (pol),
    .count_nz (count_nz),
    .reg_we (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata (reg_wdata)
);

// File: tb/frame_seq_top_tb_top.sv
module frame_seq_top_tb_top;
    localparam int FL = 5000;
    localparam int AW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_we = 1'b0;
    logic [AW-1:0] imem_waddr = '0;
    logic [15:0] imem_wdata = '0;
    logic        start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [12:0] frame_cnt;
    logic        busy, done, ser_en, ser_dat, ser_clk;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    frame_seq_top dut_i (
        .clk (clk), .rst_n (rst_n),
        .imem_we (imem_we), .imem_waddr (imem_waddr), .imem_wdata (imem_wdata),
        .start (start), .start_addr (start_addr),
        .frame_cnt (frame_cnt), .busy (busy), .done (done),
        .ser_en (ser_en), .ser_dat (ser_dat), .ser_clk (ser_clk)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] w_at(input int t);
        return 16'h8000 | 16'(t);
    endfunction
    function automatic logic [15:0] w_mv(input int a, input int d);
        return {3'b000, 5'(a), 8'(d)};
    endfunction

    task automatic put(input int a, input logic [15:0] w);
        @(posedge clk); #2;
        imem_we = 1'b1; imem_waddr = AW'(a); imem_wdata = w;
        @(posedge clk); #2;
        imem_we = 1'b0;
    endtask

    task automatic kick(input int a);
        @(posedge clk); #2;
        start = 1'b1; start_addr = AW'(a);
        @(posedge clk); #2;
        start = 1'b0;
    endtask

    // R1 frame counter sweep against an arithmetic model
    int exp_cnt = 0;
    int cnt_err = 0;
    bit wrap_seen = 0;
    always @(negedge clk) begin
        if (int'(frame_cnt) != exp_cnt) cnt_err++;
        if (rst_n) begin
            if (exp_cnt == FL - 1) wrap_seen = 1;
            exp_cnt = (exp_cnt + 1) % FL;
        end
    end

    // transfer monitor: first slot, pattern, length and clock phase
    int rec_slot [8];
    int rec_pat  [8];
    int rec_len  [8];
    int n_rec = 0;
    int k = 0;
    int cur_slot = 0;
    int cur_pat = 0;
    int clk_err = 0;
    bit prev_en = 0;
    always @(negedge clk) begin
        if (rst_n && ser_en) begin
            if (!prev_en) begin
                cur_slot = int'(frame_cnt); k = 0; cur_pat = 0;
            end
            if (k % 2 == 0) cur_pat = (cur_pat << 1) | int'(ser_dat);
            if (ser_clk != ((n_rec >= 3) ^ (k % 2 == 1))) clk_err++;
            k++;
        end else if (prev_en && n_rec < 8) begin
            rec_slot[n_rec] = cur_slot;
            rec_pat[n_rec]  = cur_pat;
            rec_len[n_rec]  = k;
            n_rec++;
        end
        prev_en = ser_en;
    end

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog run did not complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        chk(req, int'(done), 1, "done after end word");
        chk(req, int'(busy), 0, "busy after end word");
    endtask

    int e_slot [6] = '{1, 63, 703, 1005, 1102, 1304};
    int e_pat  [6] = '{'h2C, 'h15, 0, 'hA5, 'h3C, 'h81};
    int e_len  [6] = '{12, 12, 12, 16, 16, 16};

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", int'(frame_cnt), 0, "count right after reset");
        chk("R2", int'(busy), 0, "busy after reset");
        chk("R2", int'(done), 0, "done after reset");
        chk("R7", int'(ser_en), 0, "enable after reset");

        // program A: full setup crossing the wrap, padding waits, short setups
        put(0, w_at(4996));  put(1, w_mv(1, 0));   put(2, w_mv(2, 6));
        put(3, w_mv(3, 'h2C)); put(4, w_mv(4, 1));
        put(5, w_at(0));     put(6, w_at(0));      put(7, w_at(0));
        put(8, w_at(60));    put(9, w_mv(3, 'h15)); put(10, w_mv(4, 1));
        put(11, w_at(700));  put(12, w_mv(3, 0));  put(13, w_mv(4, 1));
        put(14, 16'h0000);
        // program B: inverted clock, busy command, zero count, bad code, clamp
        put(20, w_at(1000)); put(21, w_mv(1, 1));  put(22, w_mv(2, 8));
        put(23, w_mv(3, 'hA5)); put(24, w_mv(4, 1));
        put(25, w_mv(3, 'h3C)); put(26, w_mv(4, 1));
        put(27, w_at(1100)); put(28, w_mv(4, 1));
        put(29, w_at(1200)); put(30, w_mv(2, 0));  put(31, w_mv(4, 1));
        put(32, w_mv(4, 2));
        put(33, w_at(1300)); put(34, w_mv(2, 12)); put(35, w_mv(3, 'h81));
        put(36, w_mv(4, 1)); put(37, 16'h0000);

        kick(0);
        @(negedge clk);
        chk("R3", int'(busy), 1, "busy after start");
        wait_done("R2");

        kick(20);
        @(negedge clk);
        chk("R3", int'(done), 0, "done cleared by start");
        while (int'(frame_cnt) != 1050) @(negedge clk);
        kick(0); // R3 ignored while busy
        wait_done("R2");
        repeat (40) @(negedge clk);

        // R4 R5 R6 slots; R7 R9 pattern and length; R10 transfer count
        chk("R10", n_rec, 6, "number of transfers");
        for (int i = 0; i < 6; i++) begin
            chk(i == 0 ? "R4" : (i < 3 ? "R5" : "R6"), rec_slot[i], e_slot[i], "first slot");
            chk(i == 5 ? "R9" : "R7", rec_pat[i], e_pat[i], "bit pattern");
            chk(i == 5 ? "R9" : "R7", rec_len[i], e_len[i], "enable clocks");
        end
        chk("R10", rec_pat[3], 'hA5, "pattern kept despite data write");
        chk("R8", clk_err, 0, "serial clock phase errors");
        chk("R1", cnt_err, 0, "counter sweep mismatches");
        chk("R1", int'(wrap_seen), 1, "wrap observed");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule